// File: doc/BRIEF.md
# Latched Level-2 Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt line toward a parent controller. Software reaches it through a plain register port. The port has a write strobe, a byte address and write data, and read data is decoded from the address. Each source has its own mask bit. Mask bits are changed only through a write-one-to-set register and a write-one-to-clear register, and a separate register reads the current mask back. No read-modify-write is needed to change one source.

A build-time parameter picks one of two variants. In the latched variant, a rising edge on a synchronized source sets a sticky status bit, which stays set until software writes a one to that bit in the clear register. In the level variant, the status register shows the synchronized source levels directly. That variant has no clear register, so the mask registers sit at lower offsets. In both variants the output interrupt is a registered OR of status AND NOT mask.

Top module: `l2_irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1, every latched status bit is 0 and `irq_out` is 0.
- R2: Writing the mask-set register (latched 0x10, level 0x08) sets every mask bit whose data bit is 1. Bits written as 0 keep their value.
- R3: Writing the mask-clear register (latched 0x14, level 0x0C) clears every mask bit whose data bit is 1. Bits written as 0 keep their value.
- R4: In the latched variant, a rising edge on a source sets its status bit (read at 0x00). The bit stays set after the source falls.
- R5: In the latched variant, writing the clear register (0x08) clears the status bits whose data bits are 1 and leaves the others unchanged.
- R6: In the latched variant, if a new edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: In the level variant, status bit i (read at 0x00) equals the synchronized level of source i. It drops when the source deasserts.
- R8: `irq_out` is 1 one cycle after (status AND NOT mask) becomes nonzero, and 0 one cycle after it becomes zero.
- R9: The mask read-back register (latched 0x0C, level 0x04) returns the mask, with 1 meaning masked.
- R10: Reads of unmapped offsets return zero, and writes to them change neither mask nor status.
- R11: Each source passes through a two-flop synchronizer. A level-variant status bit appears two clock edges after the input changes. A latched status bit appears three edges after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Interrupt source lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Read data for `addr`, combinational |
| irq_out | output | 1 | Interrupt toward the parent controller |

## Verification
The hardest case to reach from the ports is a fresh source edge and a software clear landing on the same status bit in the same clock cycle. The stimulus raises the source on a falling edge and counts two rising edges through the synchronizer and the edge detector. It then issues the clear write so that it is sampled on the exact edge where the detector fires, and reads the status back. Masked-but-pending sources get similar handling: the source latches while masked, and the unmask write is timed to show the registered output rising exactly one cycle later.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

   typedef struct packed {
      logic [7:0] status;
      logic [7:0] clr;
      logic [7:0] mstat;
      logic [7:0] mset;
      logic [7:0] mclr;
      logic       has_clr;
   } l2irq_map_t;

   // Offsets shift when the clear register is absent.
   function automatic l2irq_map_t reg_map(input bit latched);
      l2irq_map_t m;
      m.status = 8'h00;
      if (latched) begin
         m.has_clr = 1'b1;
         m.clr     = 8'h08;
         m.mstat   = 8'h0C;
         m.mset    = 8'h10;
         m.mclr    = 8'h14;
      end else begin
         m.has_clr = 1'b0;
         m.clr     = 8'hFF;
         m.mstat   = 8'h04;
         m.mset    = 8'h08;
         m.mclr    = 8'h0C;
      end
      return m;
   endfunction

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/l2irq_status.sv
module l2irq_status #(
   parameter int NUM_SRC = 32,
   parameter bit LATCHED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lvl_in,
   input  logic [NUM_SRC-1:0] clr_vec,
   output logic [NUM_SRC-1:0] status_vec,
   output logic [NUM_SRC-1:0] edge_vec
);
   if (LATCHED) begin : g_latched
      logic [NUM_SRC-1:0] prev_q;
      logic [NUM_SRC-1:0] stat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= lvl_in;
      end

      assign edge_vec = lvl_in & ~prev_q;

      // A new edge outranks a clear of the same bit.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q <= '0;
         else        stat_q <= (stat_q & ~clr_vec) | edge_vec;
      end

      assign status_vec = stat_q;
   end else begin : g_level
      logic unused_clr;
      assign unused_clr = ^clr_vec;
      assign edge_vec   = '0;
      assign status_vec = lvl_in;
   end
endmodule

// File: rtl/l2irq_regs.sv
module l2irq_regs
   import l2irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 5,
   parameter bit LATCHED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [BUS_W-1:0]   wr_data,
   input  logic [NUM_SRC-1:0] status_vec,
   output logic [NUM_SRC-1:0] mask_vec,
   output logic [NUM_SRC-1:0] clr_vec,
   output logic [BUS_W-1:0]   rd_data
);
   localparam l2irq_map_t MAP = reg_map(LATCHED);

   logic [7:0]         a8;
   logic               hit_status, hit_clr, hit_mstat, hit_mset, hit_mclr;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] mask_q;

   assign a8         = 8'(addr);
   assign wbits      = wr_data[NUM_SRC-1:0];
   assign hit_status = (a8 == MAP.status);
   assign hit_clr    = MAP.has_clr && (a8 == MAP.clr);
   assign hit_mstat  = (a8 == MAP.mstat);
   assign hit_mset   = (a8 == MAP.mset);
   assign hit_mclr   = (a8 == MAP.mclr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= '1;
      else if (wr_en && hit_mset)  mask_q <= mask_q | wbits;
      else if (wr_en && hit_mclr)  mask_q <= mask_q & ~wbits;
   end

   assign mask_vec = mask_q;
   assign clr_vec  = (wr_en && hit_clr) ? wbits : '0;

   always_comb begin
      rd_data = '0;
      if (hit_status)     rd_data = BUS_W'(status_vec);
      else if (hit_mstat) rd_data = BUS_W'(mask_q);
   end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator #(
   parameter int NUM_SRC     = 32,
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit LATCHED     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [BUS_W-1:0]   wr_data,
   output logic [BUS_W-1:0]   rd_data,
   output logic               irq_out
);
   if (NUM_SRC < 1 || NUM_SRC > BUS_W) begin : g_bad_src
      $error("NUM_SRC must be 1..BUS_W");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must be 5..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] lvl_sync;
   logic [NUM_SRC-1:0] status_vec;
   logic [NUM_SRC-1:0] edge_vec;
   logic [NUM_SRC-1:0] mask_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic               irq_q;

   l2irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(src_in), .q_out(lvl_sync)
   );

   l2irq_status #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_status (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl_sync), .clr_vec(clr_vec),
      .status_vec(status_vec), .edge_vec(edge_vec)
   );

   l2irq_regs #(.NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
                .LATCHED(LATCHED)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .status_vec(status_vec), .mask_vec(mask_vec),
      .clr_vec(clr_vec), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_vec & ~mask_vec);
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker
   import l2irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 5,
   parameter bit LATCHED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [BUS_W-1:0]   wr_data,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] status_vec,
   input logic [NUM_SRC-1:0] mask_vec,
   input logic [NUM_SRC-1:0] edge_vec
);
   localparam l2irq_map_t MAP = reg_map(LATCHED);

   logic [7:0]         a8;
   logic [NUM_SRC-1:0] wb;
   logic               mapped;
   assign a8 = 8'(addr);
   assign wb = wr_data[NUM_SRC-1:0];
   assign mapped = (a8 == MAP.status) || (a8 == MAP.mstat) || (a8 == MAP.mset) ||
                   (a8 == MAP.mclr) || (MAP.has_clr && a8 == MAP.clr);

   p_irq_follows_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (irq_out == $past(|(status_vec & ~mask_vec))));

   p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a8 == MAP.mset) |=> ((mask_vec & $past(wb)) == $past(wb)));

   p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a8 == MAP.mclr) |=> ((mask_vec & $past(wb)) == '0));

   p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> $stable(mask_vec));

   if (LATCHED) begin : g_latched_props
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && a8 == MAP.clr) |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

      p_clear_unless_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && a8 == MAP.clr) |=> ((status_vec & $past(wb) & ~$past(edge_vec)) == '0));

      p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_vec != '0) |=> ((status_vec & $past(edge_vec)) == $past(edge_vec)));
   end
endmodule

bind l2_irq_aggregator l2irq_checker #(
   .NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LATCHED(LATCHED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .irq_out(irq_out), .status_vec(status_vec), .mask_vec(mask_vec),
   .edge_vec(edge_vec)
);

// File: tb/l2_irq_aggregator_tb.sv
module l2_irq_aggregator_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] a_src = '0, a_wdata = '0, a_rdata;
   logic [4:0]  a_addr = '0;
   logic        a_wr = 1'b0, a_irq;
   logic [31:0] b_src = '0, b_wdata = '0, b_rdata;
   logic [4:0]  b_addr = '0;
   logic        b_wr = 1'b0, b_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   l2_irq_aggregator #(.LATCHED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(a_src), .wr_en(a_wr), .addr(a_addr),
      .wr_data(a_wdata), .rd_data(a_rdata), .irq_out(a_irq));

   l2_irq_aggregator #(.LATCHED(1'b0)) u_dut_lvl (
      .clk(clk), .rst_n(rst_n), .src_in(b_src), .wr_en(b_wr), .addr(b_addr),
      .wr_data(b_wdata), .rd_data(b_rdata), .irq_out(b_irq));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_a(input logic [4:0] ad, input logic [31:0] d);
      a_addr = ad; a_wdata = d; a_wr = 1'b1;
      @(negedge clk);
      a_wr = 1'b0;
   endtask

   task automatic wr_b(input logic [4:0] ad, input logic [31:0] d);
      b_addr = ad; b_wdata = d; b_wr = 1'b1;
      @(negedge clk);
      b_wr = 1'b0;
   endtask

   task automatic rd_a(input logic [4:0] ad, output logic [31:0] d);
      a_addr = ad; #1; d = a_rdata;
   endtask

   task automatic rd_b(input logic [4:0] ad, output logic [31:0] d);
      b_addr = ad; #1; d = b_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd_a(5'h0C, v); chk("R1 latched mask at reset", v, 32'hFFFF_FFFF);
      rd_a(5'h00, v); chk("R1 latched status at reset", v, 32'h0);
      chk("R1 latched irq at reset", {31'b0, a_irq}, 32'h0);
      rd_b(5'h04, v); chk("R9 level mask readback at reset", v, 32'hFFFF_FFFF);
      chk("R1 level irq at reset", {31'b0, b_irq}, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr_a(5'h14, 32'hFFFF_FFFF);
      rd_a(5'h0C, v); chk("R3 clear all mask bits", v, 32'h0);
      wr_a(5'h10, 32'h0000_00F0);
      rd_a(5'h0C, v); chk("R2 set selected mask bits", v, 32'h0000_00F0);
      wr_a(5'h10, 32'h0000_0100);
      rd_a(5'h0C, v); chk("R2 zero bits keep mask", v, 32'h0000_01F0);
      wr_a(5'h14, 32'h0000_0030);
      rd_a(5'h0C, v); chk("R3 clear selected mask bits", v, 32'h0000_01C0);
      wr_a(5'h14, 32'hFFFF_FFFF);
   endtask

   task automatic t_latch();
      logic [31:0] v;
      a_src[3] = 1'b1;
      @(negedge clk);
      rd_a(5'h00, v); chk("R11 no status after one edge", v, 32'h0);
      @(negedge clk);
      rd_a(5'h00, v); chk("R11 no status after two edges", v, 32'h0);
      @(negedge clk);
      rd_a(5'h00, v); chk("R4 status latched after three edges", v, 32'h8);
      chk("R8 irq not yet up", {31'b0, a_irq}, 32'h0);
      @(negedge clk);
      chk("R8 irq up one cycle later", {31'b0, a_irq}, 32'h1);
      a_src[3] = 1'b0;
      repeat (4) @(negedge clk);
      rd_a(5'h00, v); chk("R4 status sticky after source falls", v, 32'h8);
      wr_a(5'h08, 32'h0000_0001);
      rd_a(5'h00, v); chk("R5 zero clear bits keep status", v, 32'h8);
      wr_a(5'h08, 32'h0000_0008);
      rd_a(5'h00, v); chk("R5 clear drops status", v, 32'h0);
      chk("R8 irq still up before register update", {31'b0, a_irq}, 32'h1);
      @(negedge clk);
      chk("R8 irq falls after clear", {31'b0, a_irq}, 32'h0);
   endtask

   task automatic t_masked_pending();
      logic [31:0] v;
      wr_a(5'h10, 32'h0000_0020);
      a_src[5] = 1'b1;
      repeat (5) @(negedge clk);
      rd_a(5'h00, v); chk("R4 masked source still latches", v, 32'h20);
      chk("R8 masked pending keeps irq low", {31'b0, a_irq}, 32'h0);
      wr_a(5'h14, 32'h0000_0020);
      chk("R8 irq low on unmask cycle", {31'b0, a_irq}, 32'h0);
      @(negedge clk);
      chk("R8 irq up after unmask", {31'b0, a_irq}, 32'h1);
      wr_a(5'h08, 32'h0000_0020);
      a_src[5] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      a_src[7] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_a(5'h08, 32'h0000_0080);
      rd_a(5'h00, v); chk("R6 edge beats same-cycle clear", v, 32'h80);
      wr_a(5'h08, 32'h0000_0080);
      rd_a(5'h00, v); chk("R5 later clear works", v, 32'h0);
      a_src[7] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr_a(5'h10, 32'h0000_0003);
      wr_a(5'h04, 32'hFFFF_FFFF);
      wr_a(5'h18, 32'hFFFF_FFFF);
      rd_a(5'h0C, v); chk("R10 latched unmapped write keeps mask", v, 32'h3);
      rd_a(5'h04, v); chk("R10 latched read of 0x04 is zero", v, 32'h0);
      rd_a(5'h1C, v); chk("R10 latched read of 0x1C is zero", v, 32'h0);
      wr_b(5'h14, 32'hFFFF_FFFF);
      rd_b(5'h04, v); chk("R10 level write to 0x14 ignored", v, 32'hFFFF_FFFF);
      rd_b(5'h10, v); chk("R10 level read of 0x10 is zero", v, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr_b(5'h0C, 32'hFFFF_FFFF);
      rd_b(5'h04, v); chk("R3 level mask clear at 0x0C", v, 32'h0);
      b_src[2] = 1'b1;
      @(negedge clk);
      rd_b(5'h00, v); chk("R11 level status after one edge", v, 32'h0);
      @(negedge clk);
      rd_b(5'h00, v); chk("R7 level status follows input", v, 32'h4);
      chk("R8 level irq not yet up", {31'b0, b_irq}, 32'h0);
      @(negedge clk);
      chk("R8 level irq up", {31'b0, b_irq}, 32'h1);
      wr_b(5'h08, 32'h0000_0004);
      rd_b(5'h04, v); chk("R2 level mask set at 0x08", v, 32'h4);
      @(negedge clk);
      chk("R8 level masked source drops irq", {31'b0, b_irq}, 32'h0);
      rd_b(5'h00, v); chk("R7 level status unaffected by mask", v, 32'h4);
      b_src[2] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rd_b(5'h00, v); chk("R7 level status drops with input", v, 32'h0);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_latch();
      t_masked_pending();
      t_set_wins();
      t_unmapped();
      t_level();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end
endmodule